// File: doc/BRIEF.md
# Program Memory Space Selector

This block sits between an instruction sequencer and its program memory. Each access carries a 12-bit word address and a kind: an instruction fetch or a data read of program space. A one-bit mode register decides where the access goes. In on-chip mode the block answers from an internal 4096-word by 16-bit constant store. In off-chip mode it drives an external read strobe and the address onto an external bus, then captures the word the device returns.

The mode register takes the level of a strap input on every clock edge while reset is held. After reset, software can rewrite the mode through a one-bit system-control write port. Across the two modes this gives up to 8K words of program space. In off-chip mode the eight highest addresses are not memory. They raise one bit of an eight-wide port-select vector, so external I/O ports 0 to 7 can be read.

A protect input guards the on-chip store against data reads. A data read that the protect input denies returns zero and raises a one-cycle violation flag. Instruction fetches from the on-chip store are never blocked.

Top module: `progspace_sel`

## Requirements
- R1: While `rstN` is low, every rising clock edge loads `modeOnChip` with `modePin`. After reset, `modePin` has no effect on the mode.
- R2: With `modeOnChip` = 1, a request leaves `extRdN` high, `extAddr` = 0 and `portSel` = 0 in the same cycle. Unless R6 applies, the next cycle returns `rspData` = {addr[3:0], addr[11:0]} XOR 16'h3C5A.
- R3: With `modeOnChip` = 0, a request drives `extRdN` low and `extAddr` = `reqAddr` in the same cycle. The next cycle returns in `rspData` the value `extRdData` held at the request's clock edge.
- R4: A write (`cfgWrEn` = 1) loads `cfgWrMode` into the mode at the end of the write cycle. A request made in the write cycle still uses the old mode, and the next request uses the new one.
- R5: In off-chip mode, a request to an address from 0xFF8 to 0xFFF sets `portSel` bit addr[2:0] and keeps `extRdN` low. Otherwise `portSel` is all zeros, including for any address in on-chip mode.
- R6: In on-chip mode, a data read (`reqIsFetch` = 0) while `protectEn` = 1 returns `rspData` = 0 in the next cycle and raises `violation` for that one cycle.
- R7: `protectEn` has no effect on instruction fetches (`reqIsFetch` = 1) or on off-chip reads: the data is returned as in R2 or R3 and `violation` stays 0.
- R8: `rspValid` is 1 exactly in the cycle after a request. `rspData` is 0 whenever `rspValid` is 0, and every output register is 0 in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| modePin | input | 1 | Strap level sampled into the mode during reset |
| cfgWrEn | input | 1 | System-control write strobe |
| cfgWrMode | input | 1 | Mode value written (1 = on-chip) |
| reqValid | input | 1 | Access request this cycle |
| reqIsFetch | input | 1 | 1 = instruction fetch, 0 = data read |
| reqAddr | input | 12 | Program word address |
| protectEn | input | 1 | Read-protect flag for the on-chip store |
| extRdData | input | 16 | Word returned by the external device |
| extAddr | output | 12 | External bus address, 0 when not an external access |
| extRdN | output | 1 | External read strobe, active low |
| portSel | output | 8 | One-hot external I/O port select |
| modeOnChip | output | 1 | Current mode, 1 = on-chip |
| rspValid | output | 1 | Response valid |
| rspData | output | 16 | Response word |
| violation | output | 1 | Protected read denied |

## Verification
The external strobe, address and port selects follow the request and the current mode in the same cycle. The bench therefore checks them a short delay after driving the inputs at the falling edge. The response word, its valid flag and the violation flag come from one register stage. They are checked at the falling edge after the rising edge that captured the request, against a model updated at that edge. A mode write shows on `modeOnChip` and on the decode one cycle later. The model applies the write only after it has scored the request made in the write cycle, so any early or late switch shows up as a mismatch.

// File: rtl/progsel_pkg.sv
package progsel_pkg;
  typedef struct packed {
    logic extAcc;
    logic romAcc;
    logic deny;
    logic portHit;
  } selStrobe_t;
endpackage

// File: rtl/progsel_ctrl.sv
module progsel_ctrl
  import progsel_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PORT_N = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modePin,
  input  logic              cfgWrEn,
  input  logic              cfgWrMode,
  input  logic              reqValid,
  input  logic              reqIsFetch,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              protectEn,
  output selStrobe_t        strobe,
  output logic              modeOnChip
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] PORT_BASE = ADDR_W'(DEPTH - PORT_N);

  logic modeQ;

  // The strap is followed for as long as reset is held; the write port
  // counts only once reset has been released.
  always_ff @(posedge clk) begin
    if (!rstN)        modeQ <= modePin;
    else if (cfgWrEn) modeQ <= cfgWrMode;
  end

  assign modeOnChip = modeQ;

  always_comb begin
    strobe.extAcc  = reqValid && !modeQ;
    strobe.romAcc  = reqValid && modeQ;
    strobe.deny    = reqValid && modeQ && !reqIsFetch && protectEn;
    strobe.portHit = reqValid && !modeQ && (reqAddr >= PORT_BASE);
  end
endmodule

// File: rtl/progsel_dp.sv
module progsel_dp
  import progsel_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int PORT_N = 8,
  parameter logic [DATA_W-1:0] ROM_SEED = 16'h3C5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  selStrobe_t        strobe,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] extRdData,
  output logic [ADDR_W-1:0] extAddr,
  output logic              extRdN,
  output logic [PORT_N-1:0] portSel,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              violation
);
  localparam int PSEL_W = (PORT_N > 1) ? $clog2(PORT_N) : 1;

  // Constant on-chip store: each word is computed from its own address,
  // so the store needs no initialisation file.
  function automatic logic [DATA_W-1:0] romWord(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] w;
    w = DATA_W'(a);
    w = w ^ (w << ADDR_W) ^ ROM_SEED;
    return w;
  endfunction

  assign extAddr = strobe.extAcc ? reqAddr : '0;
  assign extRdN  = !strobe.extAcc;

  for (genvar p = 0; p < PORT_N; p++) begin : g_port
    assign portSel[p] = strobe.portHit && (reqAddr[PSEL_W-1:0] == PSEL_W'(p));
  end

  logic [DATA_W-1:0] nextData;

  // Response source: a denied read returns zero, otherwise the on-chip
  // word or the external word, depending on where the access went.
  always_comb begin
    if (!reqValid || strobe.deny) nextData = '0;
    else if (strobe.romAcc)       nextData = romWord(reqAddr);
    else                          nextData = extRdData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspData   <= '0;
      violation <= 1'b0;
    end else begin
      rspValid  <= reqValid;
      rspData   <= nextData;
      violation <= strobe.deny;
    end
  end
endmodule

// File: rtl/progspace_sel.sv
module progspace_sel
  import progsel_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int PORT_N = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modePin,
  input  logic              cfgWrEn,
  input  logic              cfgWrMode,
  input  logic              reqValid,
  input  logic              reqIsFetch,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              protectEn,
  input  logic [DATA_W-1:0] extRdData,
  output logic [ADDR_W-1:0] extAddr,
  output logic              extRdN,
  output logic [PORT_N-1:0] portSel,
  output logic              modeOnChip,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              violation
);
  selStrobe_t strobe;

  progsel_ctrl #(.ADDR_W(ADDR_W), .PORT_N(PORT_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .modePin(modePin), .cfgWrEn(cfgWrEn),
    .cfgWrMode(cfgWrMode), .reqValid(reqValid), .reqIsFetch(reqIsFetch),
    .reqAddr(reqAddr), .protectEn(protectEn), .strobe(strobe),
    .modeOnChip(modeOnChip)
  );

  progsel_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_N(PORT_N)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqValid(reqValid),
    .reqAddr(reqAddr), .extRdData(extRdData), .extAddr(extAddr),
    .extRdN(extRdN), .portSel(portSel), .rspValid(rspValid),
    .rspData(rspData), .violation(violation)
  );
endmodule

// File: rtl/progsel_chk.sv
module progsel_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int PORT_N = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic              cfgWrMode,
  input logic              reqValid,
  input logic              reqIsFetch,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              protectEn,
  input logic [ADDR_W-1:0] extAddr,
  input logic              extRdN,
  input logic [PORT_N-1:0] portSel,
  input logic              modeOnChip,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData,
  input logic              violation
);
  localparam logic [ADDR_W-1:0] PORT_BASE = ADDR_W'((1 << ADDR_W) - PORT_N);

  a_r3_ext_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!extRdN) == (reqValid && !modeOnChip));

  a_r2_onchip_quiet: assert property (@(posedge clk) disable iff (!rstN)
    modeOnChip |-> (extRdN && extAddr == '0 && portSel == '0));

  a_r5_port_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(portSel));

  a_r5_port_range: assert property (@(posedge clk) disable iff (!rstN)
    (portSel != '0) |-> (!extRdN && extAddr >= PORT_BASE));

  a_r4_mode_write: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (modeOnChip == $past(cfgWrMode)));

  a_r6_deny_zero: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> (rspData == '0 && rspValid));

  a_r6_deny_cause: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && modeOnChip && !reqIsFetch && protectEn) |=> violation);

  a_r7_fetch_allowed: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsFetch) |=> !violation);

  a_r8_rsp_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspData == '0 && !violation));
endmodule

bind progspace_sel progsel_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_N(PORT_N)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrMode(cfgWrMode),
  .reqValid(reqValid), .reqIsFetch(reqIsFetch), .reqAddr(reqAddr),
  .protectEn(protectEn), .extAddr(extAddr), .extRdN(extRdN),
  .portSel(portSel), .modeOnChip(modeOnChip), .rspValid(rspValid),
  .rspData(rspData), .violation(violation)
);

// File: tb/progspace_sel_tb.sv
module progspace_sel_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modePin = 1'b1;
  logic        cfgWrEn = 1'b0;
  logic        cfgWrMode = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqIsFetch = 1'b0;
  logic [11:0] reqAddr = '0;
  logic        protectEn = 1'b0;
  logic [15:0] extRdData = '0;
  logic [11:0] extAddr;
  logic        extRdN;
  logic [7:0]  portSel;
  logic        modeOnChip;
  logic        rspValid;
  logic [15:0] rspData;
  logic        violation;

  int checks = 0;
  int fails = 0;
  bit mMode;

  always #10 clk = ~clk;

  progspace_sel u_dut (
    .clk(clk), .rstN(rstN), .modePin(modePin), .cfgWrEn(cfgWrEn),
    .cfgWrMode(cfgWrMode), .reqValid(reqValid), .reqIsFetch(reqIsFetch),
    .reqAddr(reqAddr), .protectEn(protectEn), .extRdData(extRdData),
    .extAddr(extAddr), .extRdN(extRdN), .portSel(portSel),
    .modeOnChip(modeOnChip), .rspValid(rspValid), .rspData(rspData),
    .violation(violation)
  );

  function automatic logic [15:0] romRef(input logic [11:0] a);
    return {a[3:0], a} ^ 16'h3C5A;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input bit pin);
    rstN = 1'b0; modePin = pin; reqValid = 1'b0; cfgWrEn = 1'b0;
    repeat (3) @(negedge clk);
    mMode = pin;
    chk("R1 strap sampled in reset", modeOnChip, pin);
    rstN = 1'b1;
    #2;
    chk("R8 reset valid", rspValid, 0);
    chk("R8 reset data", rspData, 0);
    chk("R8 reset violation", violation, 0);
  endtask

  // One clock: drive at the falling edge, check decode, check response next falling edge.
  task automatic cyc(input bit v, input bit f, input logic [11:0] a,
                     input bit prot, input bit wr, input bit wm);
    bit deny;
    bit expV;
    logic [15:0] expD;
    logic [7:0] expSel;
    string tag;
    reqValid = v; reqIsFetch = f; reqAddr = a; protectEn = prot;
    cfgWrEn = wr; cfgWrMode = wm; extRdData = 16'($urandom);
    #2;
    chk("R4 mode output", modeOnChip, mMode);
    chk(mMode ? "R2 strobe idle" : "R3 strobe", extRdN, !(v && !mMode));
    chk(mMode ? "R2 address idle" : "R3 address", extAddr, (v && !mMode) ? a : 12'h0);
    expSel = (v && !mMode && a >= 12'hFF8) ? (8'h1 << a[2:0]) : 8'h0;
    chk("R5 port select", portSel, expSel);
    deny = v && mMode && !f && prot;
    expV = v;
    expD = !v ? 16'h0 : deny ? 16'h0 : mMode ? romRef(a) : extRdData;
    tag = deny ? "R6 denied read" : !v ? "R8 idle data" :
          prot ? "R7 protect ignored" : mMode ? "R2 on-chip data" : "R3 external data";
    @(posedge clk);
    if (wr) mMode = wm;
    @(negedge clk);
    chk("R8 response valid", rspValid, expV);
    chk(tag, rspData, expD);
    chk(deny ? "R6 violation" : "R7 no violation", violation, deny);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset(1'b1);
    modePin = 1'b0;
    cyc(1, 1, 12'h000, 0, 0, 0);   // R1 strap change after reset ignored
    cyc(1, 0, 12'h123, 0, 0, 0);   // R2 data read on chip
    cyc(1, 1, 12'hFFF, 0, 0, 0);   // R5 top address on chip, no port
    cyc(1, 0, 12'hABC, 1, 0, 0);   // R6 denied
    cyc(1, 0, 12'hABD, 1, 0, 0);   // R6 back to back
    cyc(0, 0, 12'h000, 1, 0, 0);   // R6 pulse ends
    cyc(1, 1, 12'h7E1, 1, 0, 0);   // R7 fetch under protect
    cyc(1, 1, 12'h055, 0, 1, 0);   // R4 write cycle uses old mode
    cyc(1, 1, 12'h055, 0, 0, 0);   // R4 new mode
    cyc(1, 0, 12'hFF7, 0, 0, 0);   // R5 just below ports
    for (int p = 0; p < 8; p++) cyc(1, p[0], 12'hFF8 + 12'(p), 0, 0, 0);
    cyc(1, 0, 12'h3A0, 1, 0, 0);   // R7 protect off-chip
    cyc(0, 0, 12'hFFF, 0, 0, 0);   // R5 no request no port
    cyc(1, 0, 12'hFFC, 0, 1, 1);   // R4 write back to on-chip
    cyc(1, 0, 12'hFFC, 0, 0, 0);
    for (int i = 0; i < 300; i++)
      cyc(bit'($urandom), bit'($urandom), 12'($urandom) | ((i % 4 == 0) ? 12'hFF8 : 12'h0),
          bit'($urandom), ($urandom % 6) == 0, bit'($urandom));
    @(negedge clk);
    doReset(1'b0);
    modePin = 1'b1;
    cyc(1, 0, 12'h010, 1, 0, 0);   // R1 external after strap low
    cyc(1, 1, 12'hFFA, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule